// File: doc/BRIEF.md
# Packet Buffer Allocation Gate

This block guards a shared on-chip packet buffer by keeping a count of free pages and granting or refusing page requests from a transmit path and a receive path. Each page is 256 × M bytes, where M is a fixed size multiplier chosen at build time. A release input returns one page to the pool. A restore command puts the free count back to its full value without touching the host settings.

A host writes a transmit reserve, counted in pages, into the low byte of a 16-bit register. The high byte is read-only and shows the size multiplier code. If the reserve is zero, both paths share the whole pool with no limit. If the reserve is nonzero, a receive request is refused whenever the pages left would be at or below the reserve. Transmit requests ignore the reserve.

The reserve is kept on top of whatever memory is already allocated. It therefore stays the same as transmit pages are taken. Software that wants a fixed total should rewrite the reserve after it allocates or frees pages.

Top module: `pbuf_alloc_gate`

## Requirements
- R1: After reset the reserve is 0 and `free_pages` equals TOTAL_PAGES (default 64). All grant and deny outputs are low.
- R2: Reading `host_rdata` returns the reserve in bits 7:0 and the size code in bits 11:9. Bits 15:12 and bit 8 read as zero. A write sets only bits 7:0, and the new value is visible from the next clock edge. With the default code 3'b010 (M=2), the idle read value is 16'h0400.
- R3: A request sampled at a clock edge produces exactly one of grant or deny in the cycle that follows. That output lasts one cycle. A transmit request is granted whenever the free count is above zero.
- R4: With a reserve of 0, a receive request is granted whenever at least one page remains after any transmit grant in the same cycle.
- R5: With a nonzero reserve, a receive request is denied when the pages remaining after any same-cycle transmit grant are less than or equal to the reserve. Otherwise it is granted.
- R6: Transmit requests are granted down to the last page, whatever the reserve.
- R7: If both paths request in the same cycle, transmit is decided first. Receive is then judged on the count minus the transmit grant.
- R8: Each grant lowers the free count by one and each release raises it by one. Release is applied after the grant decisions of that cycle, and the count never rises above TOTAL_PAGES.
- R9: When the free count is zero, requests on both paths are denied.
- R10: The `mmu_reset` command sets the free count to TOTAL_PAGES and leaves the reserve unchanged. Any requests in that cycle are denied, and any release in that cycle is ignored.
- R11: Grants and releases never change the reserve. Only a host write changes it.
- R12: Size codes 001, 010, 011, 100 and 101 select M = 1, 2, 4, 8 and 16, and the code is shown unchanged in bits 11:9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mmu_reset | input | 1 | Restore the free count to full; the reserve is kept |
| host_wr | input | 1 | Host register write strobe |
| host_wdata | input | 16 | Host write data; only bits 7:0 are stored |
| host_rdata | output | 16 | Register read value |
| tx_req | input | 1 | Transmit page request |
| tx_grant | output | 1 | Transmit request granted (one cycle) |
| tx_deny | output | 1 | Transmit request denied (one cycle) |
| rx_req | input | 1 | Receive page request |
| rx_grant | output | 1 | Receive request granted (one cycle) |
| rx_deny | output | 1 | Receive request denied (one cycle) |
| page_release | input | 1 | Return one page to the pool |
| free_pages | output | $clog2(TOTAL_PAGES+1) (7) | Current free page count |

## Verification
Transmit and receive requests can arrive in the same cycle. A release or a restore command can also land in that same cycle. Directed cases place both requests on the last free page, and also on a count just above the reserve, to show that transmit wins and receive is judged on what is left. Random traffic then mixes requests, releases, reserve writes and restores. The bench compares every grant, deny, count and read value against its own model of the priority order.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;

  localparam int HOST_W = 16;
  localparam int RES_W  = 8;

  // size code (bits 11:9 of the register) to page multiplier
  function automatic int unsigned page_mult(input logic [2:0] code);
    case (code)
      3'b001:  return 1;
      3'b010:  return 2;
      3'b011:  return 4;
      3'b100:  return 8;
      3'b101:  return 16;
      default: return 0;
    endcase
  endfunction

  // receive admission against the transmit reserve
  function automatic logic rx_admit(input int unsigned left, input int unsigned rsv);
    return (left > 0) && ((rsv == 0) || (left > rsv));
  endfunction

  // next free count with saturation at both ends
  function automatic int unsigned next_free(input int unsigned cur, input int unsigned taken,
                                            input int unsigned given, input int unsigned top);
    int signed v;
    v = int'(cur) - int'(taken) + int'(given);
    if (v < 0) return 0;
    if (v > int'(top)) return top;
    return unsigned'(v);
  endfunction

endpackage

// File: rtl/pbuf_reserve_reg.sv
module pbuf_reserve_reg
  import pbuf_pkg::*;
#(
  parameter logic [2:0] SIZE_CODE = 3'b010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [HOST_W-1:0] wr_data,
  output logic [RES_W-1:0]  reserve,
  output logic [HOST_W-1:0] rd_data
);

  logic [RES_W-1:0] rsv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rsv_q <= '0;
    else if (wr_en) rsv_q <= wr_data[RES_W-1:0];
  end

  assign reserve = rsv_q;
  assign rd_data = {4'b0000, SIZE_CODE, 1'b0, rsv_q};

  a_r2_write_low: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[RES_W-1:0] == $past(wr_data[RES_W-1:0])));

  a_r11_reserve_held: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(reserve));

  a_r12_code_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[11:9] == SIZE_CODE) && (page_mult(rd_data[11:9]) != 0));

endmodule

// File: rtl/pbuf_policy.sv
module pbuf_policy
  import pbuf_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic             hold,
  input  logic [CW-1:0]    free_cnt,
  input  logic [RES_W-1:0] reserve,
  input  logic             tx_req,
  input  logic             rx_req,
  output logic             tx_ok,
  output logic             rx_ok
);

  int unsigned left_after_tx;

  always_comb begin
    tx_ok         = !hold && tx_req && (free_cnt != '0);
    left_after_tx = int'(free_cnt) - (tx_ok ? 1 : 0);
    rx_ok         = !hold && rx_req && rx_admit(left_after_tx, int'(reserve));
  end

endmodule

// File: rtl/pbuf_free_counter.sv
module pbuf_free_counter
  import pbuf_pkg::*;
#(
  parameter int TOTAL_PAGES = 64,
  parameter int CW          = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restore,
  input  logic          take_tx,
  input  logic          take_rx,
  input  logic          give,
  output logic [CW-1:0] free_cnt
);

  localparam logic [CW-1:0] FULL = CW'(TOTAL_PAGES);

  logic [CW-1:0] cnt_q;
  int unsigned   nxt;

  always_comb begin
    nxt = next_free(int'(cnt_q), (take_tx ? 1 : 0) + (take_rx ? 1 : 0),
                    give ? 1 : 0, TOTAL_PAGES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= FULL;
    else if (restore) cnt_q <= FULL;
    else              cnt_q <= CW'(nxt);
  end

  assign free_cnt = cnt_q;

  a_r8_never_above_total: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= FULL);

  a_r10_restore_full: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> (free_cnt == FULL));

  a_r8_release_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore && give && !take_tx && !take_rx && free_cnt != FULL) |=> (free_cnt == $past(free_cnt) + 1'b1));

endmodule

// File: rtl/pbuf_alloc_gate.sv
module pbuf_alloc_gate
  import pbuf_pkg::*;
#(
  parameter int         TOTAL_PAGES = 64,
  parameter logic [2:0] SIZE_CODE   = 3'b010,
  localparam int        CW          = $clog2(TOTAL_PAGES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mmu_reset,
  input  logic              host_wr,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  input  logic              tx_req,
  output logic              tx_grant,
  output logic              tx_deny,
  input  logic              rx_req,
  output logic              rx_grant,
  output logic              rx_deny,
  input  logic              page_release,
  output logic [CW-1:0]     free_pages
);

  logic [RES_W-1:0] reserve;
  logic             tx_ok;
  logic             rx_ok;
  logic             release_eff;

  pbuf_reserve_reg #(.SIZE_CODE(SIZE_CODE)) u_rsv (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (host_wr),
    .wr_data (host_wdata),
    .reserve (reserve),
    .rd_data (host_rdata)
  );

  pbuf_policy #(.CW(CW)) u_pol (
    .hold     (mmu_reset),
    .free_cnt (free_pages),
    .reserve  (reserve),
    .tx_req   (tx_req),
    .rx_req   (rx_req),
    .tx_ok    (tx_ok),
    .rx_ok    (rx_ok)
  );

  assign release_eff = page_release && !mmu_reset;

  pbuf_free_counter #(.TOTAL_PAGES(TOTAL_PAGES), .CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .restore  (mmu_reset),
    .take_tx  (tx_ok),
    .take_rx  (rx_ok),
    .give     (release_eff),
    .free_cnt (free_pages)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_grant <= 1'b0;
      tx_deny  <= 1'b0;
      rx_grant <= 1'b0;
      rx_deny  <= 1'b0;
    end else begin
      tx_grant <= tx_ok;
      tx_deny  <= tx_req && !tx_ok;
      rx_grant <= rx_ok;
      rx_deny  <= rx_req && !rx_ok;
    end
  end

  a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_grant && tx_deny) && !(rx_grant && rx_deny));

  a_r9_empty_deny: assert property (@(posedge clk) disable iff (!rst_n)
    (free_pages == '0 && tx_req && rx_req) |=> (tx_deny && rx_deny));

  a_r7_tx_first: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_grant && $past(tx_req) && !$past(mmu_reset)) |-> tx_grant);

  a_r5_reserve_kept: assert property (@(posedge clk) disable iff (!rst_n)
    rx_grant |-> (($past(reserve) == '0) ||
                  (int'($past(free_pages)) - (tx_grant ? 1 : 0) > int'($past(reserve)))));

  a_r10_hold_denies: assert property (@(posedge clk) disable iff (!rst_n)
    mmu_reset |=> (!tx_grant && !rx_grant));

endmodule

// File: tb/test_pbuf_alloc_gate.sv
module test_pbuf_alloc_gate;

  localparam int TOTAL = 64;
  localparam int CW    = $clog2(TOTAL + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mmu_reset = 1'b0;
  logic          host_wr = 1'b0;
  logic [15:0]   host_wdata = '0;
  logic [15:0]   host_rdata;
  logic          tx_req = 1'b0, rx_req = 1'b0, page_release = 1'b0;
  logic          tx_grant, tx_deny, rx_grant, rx_deny;
  logic [CW-1:0] free_pages;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int m_free = TOTAL;
  int m_res  = 0;

  always #4 clk = ~clk;

  pbuf_alloc_gate #(.TOTAL_PAGES(TOTAL), .SIZE_CODE(3'b010)) i_pbuf_alloc_gate (
    .clk(clk), .rst_n(rst_n), .mmu_reset(mmu_reset),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_req(tx_req), .tx_grant(tx_grant), .tx_deny(tx_deny),
    .rx_req(rx_req), .rx_grant(rx_grant), .rx_deny(rx_deny),
    .page_release(page_release), .free_pages(free_pages)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int mult_of(input int code);
    int m = 1;
    if (code < 1 || code > 5) return 0;
    for (int i = 1; i < code; i++) m = m * 2;
    return m;
  endfunction

  // one cycle: drive at negedge, check at the following negedge
  task automatic cyc(input bit tx, input bit rx, input bit rel, input bit mr,
                     input bit wr, input logic [15:0] wd);
    bit etg, etd, erg, erd;
    int left, nf;
    if (mr) begin
      etg = 0; erg = 0; nf = TOTAL;
    end else begin
      etg  = tx && (m_free > 0);
      left = m_free - (etg ? 1 : 0);
      erg  = rx && (left > 0) && (m_res == 0 || left > m_res);
      nf   = left - (erg ? 1 : 0) + (rel ? 1 : 0);
      if (nf > TOTAL) nf = TOTAL;
    end
    etd = tx && !etg;
    erd = rx && !erg;
    tx_req = tx; rx_req = rx; page_release = rel; mmu_reset = mr;
    host_wr = wr; host_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    tx_req = 0; rx_req = 0; page_release = 0; mmu_reset = 0; host_wr = 0;
    if (wr) m_res = int'(wd[7:0]);
    chk("R3 tx_grant", int'(tx_grant), int'(etg));
    chk("R3 tx_deny",  int'(tx_deny),  int'(etd));
    chk((m_res == 0) ? "R4 rx_grant" : "R5 rx_grant", int'(rx_grant), int'(erg));
    chk((m_res == 0) ? "R4 rx_deny"  : "R5 rx_deny",  int'(rx_deny),  int'(erd));
    chk("R8 free", int'(free_pages), nf);
    chk("R2 read", int'(host_rdata), 32'h0400 | m_res);
    m_free = nf;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 free", int'(free_pages), TOTAL);
    chk("R1 read", int'(host_rdata), 32'h0400);
    chk("R1 outputs", int'({tx_grant, tx_deny, rx_grant, rx_deny}), 0);
    // R12 size code
    chk("R12 code", int'(host_rdata[11:9]), 2);
    chk("R12 mult", mult_of(int'(host_rdata[11:9])), 2);

    // R2 write only low byte
    cyc(0, 0, 0, 0, 1, 16'hFFFF);
    chk("R2 high byte kept", int'(host_rdata), 32'h04FF);
    cyc(0, 0, 0, 0, 1, 16'h0000);

    // R4 reserve zero: receive drains the pool
    for (int i = 0; i < TOTAL; i++) cyc(0, 1, 0, 0, 0, 16'h0);
    chk("R4 drained", int'(free_pages), 0);
    // R9 empty denies both
    cyc(1, 1, 0, 0, 0, 16'h0);
    chk("R9 tx_deny", int'(tx_deny), 1);
    chk("R9 rx_deny", int'(rx_deny), 1);
    // R8 release after decision: request with release at zero denied
    cyc(0, 1, 1, 0, 0, 16'h0);
    chk("R8 release after decision", int'(free_pages), 1);
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 0, 16'h0);

    // R5 reserve 3, free 5
    cyc(0, 0, 0, 0, 1, 16'h0003);
    cyc(0, 1, 0, 0, 0, 16'h0);
    chk("R5 granted above reserve", int'(rx_grant), 1);
    cyc(0, 1, 0, 0, 0, 16'h0);
    chk("R5 granted at 4", int'(rx_grant), 1);
    cyc(0, 1, 0, 0, 0, 16'h0);
    chk("R5 denied at reserve", int'(rx_deny), 1);
    // R6 transmit ignores reserve
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, 16'h0);
    chk("R6 tx to zero", int'(free_pages), 0);
    // R11 reserve unchanged by allocations
    chk("R11 reserve kept", int'(host_rdata[7:0]), 3);

    // R7 same cycle on last page
    cyc(0, 0, 0, 0, 1, 16'h0000);
    cyc(0, 0, 1, 0, 0, 16'h0);
    cyc(1, 1, 0, 0, 0, 16'h0);
    chk("R7 tx wins", int'(tx_grant), 1);
    chk("R7 rx loses", int'(rx_deny), 1);
    cyc(0, 0, 1, 0, 0, 16'h0);
    cyc(0, 0, 1, 0, 0, 16'h0);
    cyc(1, 1, 0, 0, 0, 16'h0);
    chk("R7 both granted", int'(tx_grant && rx_grant), 1);
    // R7 with reserve: free 4 reserve 3 -> tx takes, rx sees 3 -> denied
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 0, 16'h0);
    cyc(0, 0, 0, 0, 1, 16'h0003);
    cyc(1, 1, 0, 0, 0, 16'h0);
    chk("R7 rx judged after tx", int'(rx_deny), 1);

    // R10 restore keeps reserve, denies requests, ignores release
    cyc(1, 1, 1, 1, 0, 16'h0);
    chk("R10 free full", int'(free_pages), TOTAL);
    chk("R10 reserve kept", int'(host_rdata[7:0]), 3);
    chk("R10 deny", int'(tx_deny && rx_deny), 1);
    // R8 saturate at total
    cyc(0, 0, 1, 0, 0, 16'h0);
    chk("R8 saturate", int'(free_pages), TOTAL);

    // random traffic
    void'($urandom(32'd2024));
    for (int i = 0; i < 4000; i++) begin
      bit tx, rx, rel, mr, wr;
      logic [15:0] wd;
      tx  = ($urandom % 100) < 45;
      rx  = ($urandom % 100) < 50;
      rel = ($urandom % 100) < 45;
      mr  = ($urandom % 200) == 0;
      wr  = ($urandom % 100) < 3;
      wd  = 16'($urandom);
      if (($urandom % 4) != 0) wd[7:0] = 8'($urandom % 12);
      cyc(tx, rx, rel, mr, wr, wd);
    end
    idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule